// File: doc/BRIEF.md
# Clock Generator Control Register Bank

This block is the control plane of a multi-output clock generator. A byte-wide register port reaches five writable control bytes and one read-only status byte. From these the block resolves a 5-bit frequency/spread code, a spread-enable flag, a global output-tristate flag and one run-enable per clock output. The frequency code comes either from four hardware select pins or from a software field, and a register bit chooses between them. The select pins are captured once after reset and then held, and they can be read back through the port.

The PLLs and the analog drivers sit outside this block. So that the enables can be seen working, the block divides its own clock into a square test clock and sends one gated copy to each of the nineteen outputs. Each gate starts and stops only on whole pulses.

Output numbering: outputs 0..7 form bank 1A, 8..10 bank 2A, 11..13 bank 1B, 14..16 bank 2B, 17 is the 48 MHz output and 18 is the reference output. The port takes a 3-bit byte address. A write lands at the clock edge on which `reg_we` is high. Reads are combinational.

Top module: `clkgen_ctrl_regs`

## Requirements
- R1: After reset, byte 0 reads 0x00, byte 1 reads 0xFF, byte 2 reads 0xFC, byte 3 reads 0xE0 and byte 4 reads 0xC0. All nineteen run-enables are 1 and `tristate_o` is 0.
- R2: `tristate_o` equals byte 0 bit 0.
- R3: When byte 0 bit 3 is 1, `freq_code_o` is {byte0[2], byte0[7:4]}, so bit 2 is the code's most significant bit. When bit 3 is 0, the code is {0, sel2B, sel1B, sel2A, sel1A} taken from the latched pins, where `sel_pins_i` bit 0 is 1A, bit 1 is 2A, bit 2 is 1B and bit 3 is 2B.
- R4: `spread_en_o` is 1 when byte 0 bit 1 is 1, or when byte 0 bit 3 is 0 and `spread_pin_i` is 1.
- R5: Run-enables map as follows. Byte 1 bits 7..0 drive outputs 7..0. Byte 2 bits 7..5 drive outputs 10..8 and bits 4..2 drive outputs 13..11. Byte 3 bits 7..5 drive outputs 16..14. Byte 4 bit 7 drives output 17 and bit 6 drives output 18. A 1 runs the output.
- R6: `sel_pins_i` is sampled on the first clock edge after reset is released. Later pin changes have no effect on the read-back or on the code.
- R7: Byte 5 reads {sel2B, sel1B, sel2A, sel1A, 0000} from the latched pins, and writes to it change nothing.
- R8: Reserved bits read 0 and ignore writes: byte 2 bits 1:0, byte 3 bits 4:0 and byte 4 bits 5:0. Addresses 6 and 7 read 0x00 and ignore writes.
- R9: Every high pulse on `tclk_o` lasts exactly TCLK_HALF cycles. A stopped output stays low. After a stop or a restart, output changes line up with edges of the shared test source.
- R10: A write is visible on `reg_rdata` and on the decoded outputs from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sel_pins_i | input | 4 | Hardware select pins {2B,1B,2A,1A} |
| spread_pin_i | input | 1 | Spread request pin |
| freq_code_o | output | 5 | Effective frequency/spread code |
| spread_en_o | output | 1 | Spread enable |
| tristate_o | output | 1 | Place all outputs in high impedance |
| clk_en_o | output | 19 | Per-output run-enable |
| tclk_o | output | 19 | Gated test clocks |

## Verification
The assertions assume that the pins are settled by the first edge after reset, that the port is only written through whole write cycles, and that the test source is a clean square wave. The bench changes the pins only after that first edge and drives every port input at the falling clock edge. It sweeps every data value through every address. While those writes land at every phase of the test clock, a monitor measures each high pulse on all nineteen outputs.

// File: rtl/clkgen_pkg.sv
// Shared constants for the clock generator control bank.
// Assumes 19 outputs grouped as 8/3/3/3 bank clocks plus USB and reference.
package clkgen_pkg;
    localparam int NUM_OUT  = 19;
    localparam int NUM_WREG = 5;
    localparam int AW       = 3;
    localparam int SEL_W    = 4;
    localparam int CODE_W   = 5;

    // Writable bit mask for each byte address.
    function automatic logic [7:0] wr_mask(input logic [AW-1:0] a);
        case (a)
            3'd0:    return 8'hFF;
            3'd1:    return 8'hFF;
            3'd2:    return 8'hFC;
            3'd3:    return 8'hE0;
            3'd4:    return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    // Reset value of each byte: enables on, controls cleared.
    function automatic logic [7:0] rst_value(input logic [AW-1:0] a);
        return (a == 3'd0) ? 8'h00 : wr_mask(a);
    endfunction
endpackage

// File: rtl/clkgen_sel_latch.sv
// Captures the hardware select pins once, on the first edge after reset.
// Assumes the pins are settled by that edge; the value is held afterwards.
module clkgen_sel_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] sel_q,
    output logic         done_q
);
    // Take one snapshot of the pins, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            sel_q  <= pins_i;
            done_q <= 1'b1;
        end
    end

    a_r6_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && $past(done_q)) |-> $stable(sel_q));
endmodule

// File: rtl/clkgen_regfile.sv
// Control byte storage, read mux and output-enable mapping.
// Assumes a write lands at the edge where we is high; reads are combinational.
module clkgen_regfile
    import clkgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [7:0]         wdata,
    input  logic [SEL_W-1:0]   sel_q,
    output logic [7:0]         rdata,
    output logic [7:0]         ctl0,
    output logic [NUM_OUT-1:0] en_vec
);
    logic [7:0] regs_q [NUM_WREG];

    // One storage byte per writable address; only writable bits can change.
    for (genvar g = 0; g < NUM_WREG; g++) begin : g_byte
        localparam logic [AW-1:0] ADDR = AW'(g);
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= rst_value(ADDR);
            else if (we && addr == ADDR)
                q <= wdata & wr_mask(ADDR);
        end
        assign regs_q[g] = q;
    end

    // Read mux: storage bytes, latched-pin status byte, zeros elsewhere.
    always_comb begin
        rdata = 8'h00;
        if (int'(addr) < NUM_WREG)
            rdata = regs_q[addr];
        else if (addr == 3'd5)
            rdata = {sel_q[3], sel_q[2], sel_q[1], sel_q[0], 4'b0000};
    end

    // Scatter the enable bits onto the output numbering.
    always_comb begin
        en_vec        = '0;
        en_vec[7:0]   = regs_q[1];
        en_vec[10:8]  = regs_q[2][7:5];
        en_vec[13:11] = regs_q[2][4:2];
        en_vec[16:14] = regs_q[3][7:5];
        en_vec[17]    = regs_q[4][7];
        en_vec[18]    = regs_q[4][6];
    end

    assign ctl0 = regs_q[0];

    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 3'd1) |=> (regs_q[1] == $past(wdata)));
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |=> $stable(regs_q[3]));
endmodule

// File: rtl/clkgen_tclk_div.sv
// Divides the block clock into a square test source of period 2*HALF.
// Provides both the registered source and its next value for the gates.
module clkgen_tclk_div #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic src_q,
    output logic src_d
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap  = (cnt_q == LAST);
    assign src_d = wrap ? ~src_q : src_q;

    // Count out a half period, then toggle the source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            src_q <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            src_q <= src_d;
        end
    end
endmodule

// File: rtl/clkgen_clk_gate.sv
// Whole-pulse clock gate for one output.
// The run flag is resampled only while the source is low, so a pulse is never cut short.
module clkgen_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src_q,
    input  logic src_d,
    input  logic en,
    output logic out_q
);
    logic run_q;
    logic run_d;

    assign run_d = src_q ? run_q : en;

    // Hold the run flag through a high phase; register the gated source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            run_q <= run_d;
            out_q <= src_d & run_d;
        end
    end

    a_r9_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> $rose(src_q));
    a_r9_fall_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q) |-> !src_q);
endmodule

// File: rtl/clkgen_ctrl_regs.sv
// Top of the clock generator control bank: registers, pin latch, code
// resolution, and gated test clocks for every output.
// Assumes a single clock domain and synchronous active-low reset.
module clkgen_ctrl_regs
    import clkgen_pkg::*;
#(
    parameter int TCLK_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [SEL_W-1:0]   sel_pins_i,
    input  logic               spread_pin_i,
    output logic [CODE_W-1:0]  freq_code_o,
    output logic               spread_en_o,
    output logic               tristate_o,
    output logic [NUM_OUT-1:0] clk_en_o,
    output logic [NUM_OUT-1:0] tclk_o
);
    logic [SEL_W-1:0] sel_q;
    logic             sel_done;
    logic [7:0]       ctl0;
    logic             src_q;
    logic             src_d;
    logic             sw_mode;

    clkgen_sel_latch #(.W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .pins_i(sel_pins_i),
        .sel_q(sel_q), .done_q(sel_done)
    );

    clkgen_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .sel_q(sel_q), .rdata(reg_rdata),
        .ctl0(ctl0), .en_vec(clk_en_o)
    );

    clkgen_tclk_div #(.HALF(TCLK_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .src_q(src_q), .src_d(src_d)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
        clkgen_clk_gate u_gate (
            .clk(clk), .rst_n(rst_n), .src_q(src_q), .src_d(src_d),
            .en(clk_en_o[i]), .out_q(tclk_o[i])
        );
    end

    assign sw_mode = ctl0[3];

    // Resolve code and spread from either the software field or the pins.
    always_comb begin
        if (sw_mode)
            freq_code_o = {ctl0[2], ctl0[7:4]};
        else
            freq_code_o = {1'b0, sel_q[3], sel_q[2], sel_q[1], sel_q[0]};
        spread_en_o = ctl0[1] | (~sw_mode & spread_pin_i);
        tristate_o  = ctl0[0];
    end

    a_r3_hw_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_done && $past(sel_done) && !sw_mode && $past(!sw_mode))
            |-> $stable(freq_code_o));
    a_r3_hw_code_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_mode) |-> !freq_code_o[4]);
endmodule

// File: tb/sim_clkgen_ctrl_regs.sv
module sim_clkgen_ctrl_regs;
    localparam int HALF = 2;
    localparam int NO   = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [3:0]  sel_pins_i = 4'b1010;
    logic        spread_pin_i = 1'b0;
    logic [4:0]  freq_code_o;
    logic        spread_en_o;
    logic        tristate_o;
    logic [NO-1:0] clk_en_o;
    logic [NO-1:0] tclk_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    bit mon_on = 0;
    int hi_len [NO];
    int rises  [NO];
    logic [NO-1:0] prev_out = '0;
    logic [7:0] shadow [8];

    always #5 clk = ~clk;

    clkgen_ctrl_regs #(.TCLK_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sel_pins_i(sel_pins_i),
        .spread_pin_i(spread_pin_i), .freq_code_o(freq_code_o),
        .spread_en_o(spread_en_o), .tristate_o(tristate_o),
        .clk_en_o(clk_en_o), .tclk_o(tclk_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int a);
        case (a)
            0, 1: return 8'hFF;
            2: return 8'hFC;
            3: return 8'hE0;
            4: return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [NO-1:0] en_of();
        logic [NO-1:0] e;
        for (int i = 0; i < 8; i++) e[i] = shadow[1][i];
        for (int i = 0; i < 3; i++) begin
            e[8 + i]  = shadow[2][5 + i];
            e[11 + i] = shadow[2][2 + i];
            e[14 + i] = shadow[3][5 + i];
        end
        e[17] = shadow[4][7];
        e[18] = shadow[4][6];
        return e;
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a < 5) shadow[a] = d & mask_of(a);
    endtask

    task automatic rd_check(input string req, input int a, input logic [7:0] exp);
        reg_addr = 3'(a);
        #1;
        check(req, reg_rdata, exp);
    endtask

    // Measure every high pulse on every output at the falling edge (R9).
    always @(negedge clk) begin
        if (mon_on) begin
            for (int i = 0; i < NO; i++) begin
                if (tclk_o[i]) begin
                    if (!prev_out[i]) rises[i]++;
                    hi_len[i]++;
                end else if (hi_len[i] != 0) begin
                    check("R9 pulse width", hi_len[i], HALF);
                    hi_len[i] = 0;
                end
            end
            prev_out = tclk_o;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NO; i++) begin hi_len[i] = 0; rises[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sel_pins_i = 4'b0101;
        mon_on = 1;
        for (int a = 0; a < 5; a++) begin
            shadow[a] = (a == 0) ? 8'h00 : mask_of(a);
            rd_check("R1 reset byte", a, shadow[a]);
        end
        check("R1 reset enables", clk_en_o, {NO{1'b1}});
        check("R1 reset tristate", tristate_o, 0);
        rd_check("R7 latched pins readback", 5, 8'hA0);
        check("R3 hw code from latched pins", freq_code_o, 5'b01010);
        repeat (5) @(negedge clk);
        sel_pins_i = 4'b1111;
        #1;
        check("R6 later pin change ignored", freq_code_o, 5'b01010);
        rd_check("R6 readback held", 5, 8'hA0);

        // Byte 0 sweep: code source, spread, tristate, read-back.
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            wr(0, b);
            rd_check("R10 byte0 readback", 0, b);
            check("R2 tristate", tristate_o, b[0]);
            check("R3 code", freq_code_o, b[3] ? {b[2], b[7:4]} : 5'b01010);
            for (int p = 0; p < 2; p++) begin
                spread_pin_i = p[0];
                #1;
                check("R4 spread", spread_en_o, b[1] | (!b[3] & p[0]));
            end
        end
        wr(0, 8'h00);

        // Enable bytes, status byte and unused addresses: every value.
        for (int a = 1; a < 8; a++) begin
            for (int v = 0; v < 256; v++) begin
                wr(a, 8'(v));
                if (a == 5)
                    rd_check("R7 status write ignored", a, 8'hA0);
                else
                    rd_check("R8 masked readback", a, 8'(v) & mask_of(a));
                check("R5 enable map", clk_en_o, en_of());
                if (v[2:0] == 3'd3) repeat (v[5:3]) @(negedge clk);
            end
        end
        for (int a = 0; a < 5; a++) rd_check("R8 no cross-write", a, shadow[a]);

        // Stop bank 1A and confirm silence while others keep running.
        wr(1, 8'h00);
        repeat (2 * HALF + 2) @(negedge clk);
        for (int i = 0; i < NO; i++) rises[i] = 0;
        for (int k = 0; k < 10 * HALF; k++) begin
            @(negedge clk);
            check("R9 stopped output low", tclk_o[7:0], 8'h00);
        end
        check("R9 running output toggles", rises[8] > 0, 1);
        wr(1, 8'h01);
        repeat (4 * HALF + 2) @(negedge clk);
        check("R9 restarted output toggles", rises[0] > 0, 1);
        check("R9 other stopped output idle", rises[1], 0);
        repeat (4) @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end
endmodule